// File: doc/BRIEF.md
# Multichannel Sample Word Packer

This block gathers one-bit samples from up to sixteen logic probes and turns them into a byte stream for a byte-wide FIFO sink. On every sample strobe, each probe shifts its current level into its own sixteen-bit word. After sixteen strobes the group is complete. The words are copied into a holding buffer, and the next sixteen samples are captured while the buffered group drains.

A group drains channel by channel. Each enabled probe sends its word as two bytes, the low byte first, and the probes follow one another in ascending index order. Disabled probes send nothing. The enable mask is snapshotted when a group starts, so a mask change during capture only affects the following group. If a group completes before the previous one has fully drained, the new group is discarded and a sticky overflow flag is raised.

Top module: `probe_word_packer`

## Requirements
- R1: While `rst` is high, `out_valid` and `overflow` are driven low on the following clock edge.
- R2: Bit k of a probe's word holds that probe's level at the k-th strobe of the group, so bit 0 is the earliest sample. A 1 means the probe was high and a 0 means it was low.
- R3: Each enabled probe emits its word as exactly two bytes: bits 7:0 first, then bits 15:8.
- R4: Within a group, only probes whose mask bit is 1 emit bytes, in ascending index order. A group therefore yields 2 × popcount(mask) bytes.
- R5: The mask used for a group is the value of `probe_enable` at that group's first strobe. Changes to it during the remaining fifteen strobes do not alter that group.
- R6: A byte transfers only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged on the next cycle.
- R7: The first byte of a group is presented with `out_valid` high on the cycle right after the edge that captures the group's sixteenth strobe. Capture of the next group proceeds while the current group drains.
- R8: If a group completes while bytes of the previous group remain unsent (not counting a final byte transferring on that same edge), `overflow` rises, stays high until reset, the new group is discarded, and the previous group's drain continues unchanged.
- R9: A group captured with an all-zero mask emits no bytes and does not raise `overflow`.
- R10: Samples are taken only on cycles where `sample_stb` is high. Probe activity on other cycles does not appear in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Take one sample of all probes this cycle |
| probe_in | input | 16 | Current probe levels |
| probe_enable | input | 16 | Per-probe enable, snapshotted at group start |
| out_ready | input | 1 | Sink can accept a byte |
| out_data | output | 8 | Byte being offered |
| out_valid | output | 1 | `out_data` is valid |
| overflow | output | 1 | Sticky: a group was lost to a slow drain |

## Verification
The assertions take three things for granted. Reset is held high from time zero through at least one edge. The strobe, probe, mask and ready inputs are synchronous to `clk` and settle before each rising edge. The overflow checks also assume the sink may hold `out_ready` low for any length of time. To respect this, the stimulus changes every input only on the falling edge, starts with reset asserted, and keeps probe levels toggling on non-strobe cycles. Outside the one deliberate overflow scenario, it holds back each group's final strobe until the expected stream has drained, so no group is ever lost unintentionally.

// File: rtl/ppk_pkg.sv
package ppk_pkg;

    localparam int unsigned PPK_PROBES  = 16;
    localparam int unsigned PPK_SAMPLES = 16;
    localparam int unsigned PPK_BYTE_W  = 8;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_e;

    function automatic int unsigned bytes_per_word(input int unsigned samples);
        return (samples + PPK_BYTE_W - 1) / PPK_BYTE_W;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ppk_capture.sv
module ppk_capture
    import ppk_pkg::*;
#(
    parameter int unsigned NUM_PROBES    = PPK_PROBES,
    parameter int unsigned GROUP_SAMPLES = PPK_SAMPLES
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         stb,
    input  logic [NUM_PROBES-1:0]                        probes,
    input  logic [NUM_PROBES-1:0]                        mask_in,
    output logic                                         grp_done,
    output logic [NUM_PROBES-1:0][GROUP_SAMPLES-1:0]     words_next,
    output logic [NUM_PROBES-1:0]                        mask_next
);

    localparam int unsigned CW = idx_width(GROUP_SAMPLES);
    localparam logic [CW-1:0] LAST_SLOT = CW'(GROUP_SAMPLES - 1);

    logic [CW-1:0]           slot_q;
    logic [NUM_PROBES-1:0]   mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            mask_q <= '0;
        end else if (stb) begin
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            if (slot_q == '0) begin
                mask_q <= mask_in;
            end
        end
    end

    assign grp_done  = stb && (slot_q == LAST_SLOT);
    assign mask_next = (slot_q == '0) ? mask_in : mask_q;

    for (genvar p = 0; p < NUM_PROBES; p++) begin : g_lane
        logic [GROUP_SAMPLES-2:0] hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q <= '0;
            end else if (stb) begin
                if (GROUP_SAMPLES > 2) begin
                    hist_q <= {probes[p], hist_q[GROUP_SAMPLES-2:1]};
                end else begin
                    hist_q <= probes[p];
                end
            end
        end

        assign words_next[p] = {probes[p], hist_q};
    end

    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(slot_q)); // R10

endmodule

// File: rtl/ppk_hold.sv
module ppk_hold
    import ppk_pkg::*;
#(
    parameter int unsigned NUM_PROBES    = PPK_PROBES,
    parameter int unsigned GROUP_SAMPLES = PPK_SAMPLES
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         grp_done,
    input  logic [NUM_PROBES-1:0][GROUP_SAMPLES-1:0]     words_next,
    input  logic [NUM_PROBES-1:0]                        mask_next,
    input  logic                                         drain_busy,
    input  logic                                         drain_last,
    output logic                                         load,
    output logic [NUM_PROBES-1:0][GROUP_SAMPLES-1:0]     held_words,
    output logic [NUM_PROBES-1:0]                        held_mask,
    output logic                                         overflow
);

    logic still_draining;

    assign still_draining = drain_busy && !drain_last;
    assign load           = grp_done && !still_draining;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_words <= '0;
            held_mask  <= '0;
            overflow   <= 1'b0;
        end else begin
            if (load) begin
                held_words <= words_next;
                held_mask  <= mask_next;
            end
            if (grp_done && still_draining) begin
                overflow <= 1'b1;
            end
        end
    end

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R8
    AST_LOST_GROUP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        grp_done && drain_busy && !drain_last |=> overflow); // R8
    AST_LOAD_STARTS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        load && (|mask_next) |=> drain_busy); // R7
    AST_EMPTY_GROUP_IDLE: assert property (@(posedge clk) disable iff (rst)
        load && !(|mask_next) |=> !drain_busy); // R9

endmodule

// File: rtl/ppk_serializer.sv
module ppk_serializer
    import ppk_pkg::*;
#(
    parameter int unsigned NUM_PROBES    = PPK_PROBES,
    parameter int unsigned GROUP_SAMPLES = PPK_SAMPLES
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         load,
    input  logic [NUM_PROBES-1:0]                        load_mask,
    input  logic [NUM_PROBES-1:0][GROUP_SAMPLES-1:0]     held_words,
    input  logic [NUM_PROBES-1:0]                        held_mask,
    input  logic                                         ready,
    output logic                                         valid,
    output logic [PPK_BYTE_W-1:0]                        data,
    output logic                                         busy,
    output logic                                         last_fire
);

    localparam int unsigned NB = bytes_per_word(GROUP_SAMPLES);
    localparam int unsigned IW = idx_width(NUM_PROBES);
    localparam int unsigned BW = idx_width(NB);
    localparam logic [BW-1:0] LAST_BYTE = BW'(NB - 1);

    drain_e        state_q;
    logic [IW-1:0] cur_q;
    logic [BW-1:0] bsel_q;
    logic [IW-1:0] first_idx;
    logic [IW-1:0] next_idx;
    logic          has_next;
    logic          fire;

    always_comb begin
        first_idx = '0;
        for (int i = NUM_PROBES - 1; i >= 0; i--) begin
            if (load_mask[i]) begin
                first_idx = IW'(i);
            end
        end
    end

    always_comb begin
        next_idx = '0;
        has_next = 1'b0;
        for (int i = NUM_PROBES - 1; i >= 0; i--) begin
            if (held_mask[i] && (i > int'(cur_q))) begin
                next_idx = IW'(i);
                has_next = 1'b1;
            end
        end
    end

    always_comb begin
        data = '0;
        for (int b = 0; b < NB; b++) begin
            if (BW'(b) == bsel_q) begin
                data = held_words[cur_q][b*PPK_BYTE_W +: PPK_BYTE_W];
            end
        end
    end

    assign valid     = (state_q == DR_SEND);
    assign busy      = valid;
    assign fire      = valid && ready;
    assign last_fire = fire && (bsel_q == LAST_BYTE) && !has_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DR_IDLE;
            cur_q   <= '0;
            bsel_q  <= '0;
        end else if (load) begin
            state_q <= (|load_mask) ? DR_SEND : DR_IDLE;
            cur_q   <= first_idx;
            bsel_q  <= '0;
        end else if (fire) begin
            if (bsel_q != LAST_BYTE) begin
                bsel_q <= bsel_q + 1'b1;
            end else if (has_next) begin
                cur_q  <= next_idx;
                bsel_q <= '0;
            end else begin
                state_q <= DR_IDLE;
            end
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(data)); // R6
    AST_EMIT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        valid |-> held_mask[cur_q]); // R4

endmodule

// File: rtl/probe_word_packer.sv
module probe_word_packer
    import ppk_pkg::*;
#(
    parameter int unsigned NUM_PROBES    = PPK_PROBES,
    parameter int unsigned GROUP_SAMPLES = PPK_SAMPLES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_stb,
    input  logic [NUM_PROBES-1:0]    probe_in,
    input  logic [NUM_PROBES-1:0]    probe_enable,
    input  logic                     out_ready,
    output logic [PPK_BYTE_W-1:0]    out_data,
    output logic                     out_valid,
    output logic                     overflow
);

    logic                                     grp_done;
    logic [NUM_PROBES-1:0][GROUP_SAMPLES-1:0] words_next;
    logic [NUM_PROBES-1:0]                    mask_next;
    logic                                     load;
    logic [NUM_PROBES-1:0][GROUP_SAMPLES-1:0] held_words;
    logic [NUM_PROBES-1:0]                    held_mask;
    logic                                     drain_busy;
    logic                                     drain_last;

    ppk_capture #(
        .NUM_PROBES    (NUM_PROBES),
        .GROUP_SAMPLES (GROUP_SAMPLES)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .stb        (sample_stb),
        .probes     (probe_in),
        .mask_in    (probe_enable),
        .grp_done   (grp_done),
        .words_next (words_next),
        .mask_next  (mask_next)
    );

    ppk_hold #(
        .NUM_PROBES    (NUM_PROBES),
        .GROUP_SAMPLES (GROUP_SAMPLES)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .grp_done   (grp_done),
        .words_next (words_next),
        .mask_next  (mask_next),
        .drain_busy (drain_busy),
        .drain_last (drain_last),
        .load       (load),
        .held_words (held_words),
        .held_mask  (held_mask),
        .overflow   (overflow)
    );

    ppk_serializer #(
        .NUM_PROBES    (NUM_PROBES),
        .GROUP_SAMPLES (GROUP_SAMPLES)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_mask  (mask_next),
        .held_words (held_words),
        .held_mask  (held_mask),
        .ready      (out_ready),
        .valid      (out_valid),
        .data       (out_data),
        .busy       (drain_busy),
        .last_fire  (drain_last)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid && !overflow); // R1

endmodule

// File: tb/probe_word_packer_tb.sv
module probe_word_packer_tb;

    localparam int NP = 16;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_stb = 1'b0;
    logic [NP-1:0] probe_in = '0;
    logic [NP-1:0] probe_enable = '0;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          overflow;

    always #2 clk = ~clk;

    probe_word_packer u_dut (
        .clk          (clk),
        .rst          (rst),
        .sample_stb   (sample_stb),
        .probe_in     (probe_in),
        .probe_enable (probe_enable),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .overflow     (overflow)
    );

    int         checks = 0;
    int         fails  = 0;
    logic [7:0] exp_q[$];
    logic [NS-1:0] msamp[NP];
    int         mcnt = 0;
    logic [NP-1:0] msnap = '0;
    int         ready_mode = 0;   // 0 random, 1 hold low, 2 hold high
    string      cur_tag = "R4";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected bytes of one group: ascending probes, low byte then high byte
    function automatic void push_group(input logic [NP-1:0] m);
        for (int p = 0; p < NP; p++) begin
            if (m[p]) begin
                exp_q.push_back(msamp[p][7:0]);
                exp_q.push_back(msamp[p][15:8]);
            end
        end
    endfunction

    // sink and stream monitor
    initial begin
        forever begin
            @(negedge clk);
            case (ready_mode)
                1:       out_ready = 1'b0;
                2:       out_ready = 1'b1;
                default: out_ready = ($urandom % 4) != 0;
            endcase
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, " unexpected byte"}, out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, {cur_tag, " stream byte"}, out_data, e);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_stb = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        mcnt = 0;
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(overflow == 1'b0, "R1 overflow in reset", overflow, 0);
        rst = 1'b0;
    endtask

    task automatic do_strobe(input logic [NP-1:0] pv, input bit wait_empty, input bit keep);
        if (mcnt == NS - 1 && wait_empty) begin
            while (exp_q.size() != 0) @(negedge clk);
        end
        @(negedge clk);
        if (mcnt == 0) msnap = probe_enable;
        sample_stb = 1'b1;
        probe_in = pv;
        for (int p = 0; p < NP; p++) msamp[p][mcnt] = pv[p];
        if (mcnt == NS - 1) begin
            if (keep) push_group(msnap);
            mcnt = 0;
        end else begin
            mcnt++;
        end
        @(negedge clk);
        sample_stb = 1'b0;
        probe_in = 16'($urandom);   // R10: noise between strobes
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            probe_in = 16'($urandom);
        end
    endtask

    task automatic rand_group(input logic [NP-1:0] m);
        probe_enable = m;
        for (int s = 0; s < NS; s++) begin
            idle($urandom % 3);
            do_strobe(16'($urandom), 1'b1, 1'b1);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        idle(3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2 R3 R7 R6: directed single probe, word 0x8009
        cur_tag = "R2 R3";
        ready_mode = 1;
        probe_enable = 16'h0001;
        for (int s = 0; s < NS; s++) begin
            logic [NP-1:0] v;
            v = '0;
            v[0] = (s == 0) || (s == 3) || (s == 15);
            do_strobe(v, 1'b1, 1'b1);
        end
        check(out_valid == 1'b1, "R7 valid after last strobe", out_valid, 1);
        check(out_data == 8'h09, "R2 first byte earliest bit0", out_data, 8'h09);
        idle(3);
        check(out_valid == 1'b1, "R6 valid held while stalled", out_valid, 1);
        check(out_data == 8'h09, "R6 data held while stalled", out_data, 8'h09);
        ready_mode = 0;
        drain();

        // R4 sparse and full masks
        cur_tag = "R4";
        rand_group(16'h8001);
        rand_group(16'hFFFF);
        rand_group(16'h0420);
        drain();

        // R5: mask changes mid-group
        cur_tag = "R5";
        probe_enable = 16'h0003;
        for (int s = 0; s < NS; s++) begin
            if (s == 5) probe_enable = 16'h0100;
            do_strobe(16'($urandom), 1'b1, 1'b1);
        end
        rand_group(16'h0100);
        drain();

        // R9: empty mask gives nothing
        cur_tag = "R9";
        rand_group(16'h0000);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            check(seen == 0, "R9 no bytes for empty mask", seen, 0);
            check(overflow == 1'b0, "R9 no overflow", overflow, 0);
        end

        // R7 R4 R10: random groups overlapping capture with drain
        cur_tag = "R7 R10";
        for (int g = 0; g < 30; g++) begin
            logic [NP-1:0] m;
            m = 16'($urandom);
            if (g % 5 == 0) m = m & 16'($urandom);
            rand_group(m);
        end
        drain();
        check(overflow == 1'b0, "R8 no overflow on paced traffic", overflow, 0);

        // R8: overflow with stalled sink
        cur_tag = "R8";
        ready_mode = 1;
        probe_enable = 16'hFFFF;
        for (int s = 0; s < NS; s++) do_strobe(16'($urandom), 1'b1, 1'b1);
        check(overflow == 1'b0, "R8 first group no overflow", overflow, 0);
        for (int s = 0; s < NS; s++) do_strobe(16'($urandom), 1'b0, 1'b0);
        @(negedge clk);
        check(overflow == 1'b1, "R8 overflow raised", overflow, 1);
        ready_mode = 2;
        drain();
        check(out_valid == 1'b0, "R8 lost group not sent", out_valid, 0);
        idle(10);
        check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
        ready_mode = 0;
        do_reset();
        cur_tag = "R4";
        rand_group(16'h00F0);
        drain();
        check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule